// File: doc/BRIEF.md
# SPI Memory Readback Slave

This block is a serial slave that lets an external host read a DSP's internal memories and status words. The host drops chip select and shifts in an 8-bit command and then a 16-bit address. While these 24 header bits arrive, the slave sends each one back on its data output. After the header it streams 24-bit data words, one after another, until chip select goes high. Each new word comes from the next consecutive address.

The block runs entirely on the system clock. The serial clock, chip select and serial input pass through synchronizers and are then edge-detected, so the serial clock must be slow compared with the system clock. Each half period of the serial clock must last at least 6 system clock cycles.

Data comes from a plain synchronous read port. The slave asserts `mem_rd_en` for one cycle with a space code and an address. The memory presents `mem_rdata` on the next cycle. The slave always keeps the next word fetched one word ahead of the shifter. There is no back-pressure on this port: the memory must answer every request in exactly one cycle. Which spaces may be read depends on `dsp_run`, which is sampled when the header completes.

Top module: `spi_rb_slave`

## Requirements
- R1: After reset, `spi_so_oe` is 0, `mem_rd_en` is 0 and `acc_err` is 0.
- R2: `spi_si` is sampled on rising `spi_sclk` edges. The first 8 bits form the command and the next 16 bits form the address, both MSB first. A command is valid only if bits 7..3 are zero and bits 2..0 are nonzero. Bits 2..0 select the space: 1 program RAM, 2 coefficient RAM, 3 offset registers, 4 control registers, 5 device ID, 6 CRC result, 7 error status.
- R3: `spi_so_oe` stays 0 until the first falling `spi_sclk` edge of a transfer. On falling edge k (k = 1..24), `spi_so` presents header bit k.
- R4: From falling edge 25 onward, `spi_so` carries 24-bit data words MSB first, one bit per falling edge. The words are read through `mem_space`/`mem_addr`, and `mem_rdata` is taken one cycle after `mem_rd_en`.
- R5: Each further word comes from the previous address plus one, wrapping from 0xFFFF to 0x0000. This continues for as long as the serial clock runs.
- R6: For space 1 (program RAM), the first word is read from address 0, whatever the received address field holds.
- R7: Spaces 1, 2 and 3 requested while `dsp_run` is 1 produce all-zero data and no `mem_rd_en`. They also set `acc_err`, which then stays 1 until reset.
- R8: Spaces 4 to 7 are read normally whether `dsp_run` is 0 or 1.
- R9: An invalid command produces all-zero data and no `mem_rd_en`, and leaves `acc_err` unchanged.
- R10: `spi_si` has no effect during the data phase.
- R11: While `spi_csn` is 1, `spi_so_oe` is 0 in the same cycle. Raising `spi_csn` mid-transfer discards the partial header, so the next transfer starts with a fresh header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out, low when not enabled |
| spi_so_oe | output | 1 | Output enable for `spi_so` |
| dsp_run | input | 1 | 1 when the DSP is running, 0 while it is held in reset |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_space | output | 3 | Space code of the request (R2 encoding) |
| mem_addr | output | 16 | Word address of the request |
| mem_rdata | input | 24 | Read data, valid the cycle after `mem_rd_en` |
| acc_err | output | 1 | Sticky flag for a blocked RAM access |

## Verification
The checker watches the following on every cycle:
- the output enable stays off whenever chip select is high;
- read requests are single-cycle and never carry the null space code;
- the request address does not move between requests;
- the access error flag never clears.

The content of the serial stream can only be shown by the directed scenarios. These cover:
- the echo timing and the bit alignment of the data;
- auto-increment and address wrap;
- program RAM starting at zero;
- blocked and invalid commands returning zeros;
- noise on the serial input during the data phase;
- recovery after an aborted header.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

  localparam int SPACE_W = 3;

  typedef enum logic [SPACE_W-1:0] {
    SP_NONE  = 3'd0,
    SP_PROG  = 3'd1,
    SP_COEF  = 3'd2,
    SP_OFFS  = 3'd3,
    SP_CTRL  = 3'd4,
    SP_IDENT = 3'd5,
    SP_CRC   = 3'd6,
    SP_ERRST = 3'd7
  } space_e;

  typedef enum logic [1:0] {
    FM_IDLE = 2'd0,
    FM_READ = 2'd1,
    FM_ZERO = 2'd2
  } fetch_mode_e;

  // RAM-type spaces are only reachable while the DSP core is held in reset
  function automatic logic is_ram(input space_e sp);
    return (sp == SP_PROG) || (sp == SP_COEF) || (sp == SP_OFFS);
  endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic si_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic si_s
);

  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sclk_p;
  logic [N-1:0] csn_p;
  logic [N-1:0] si_p;
  logic         sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      csn_p  <= '1;
      si_p   <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[N-2:0], sclk_i};
      csn_p  <= {csn_p[N-2:0], csn_i};
      si_p   <= {si_p[N-2:0], si_i};
      sclk_d <= sclk_p[N-1];
    end
  end

  assign sclk_rise = sclk_p[N-1] & ~sclk_d;
  assign sclk_fall = ~sclk_p[N-1] & sclk_d;
  assign cs_act    = ~csn_p[N-1];
  assign si_s      = si_p[N-1];

endmodule

// File: rtl/spi_rb_hdr.sv
module spi_rb_hdr #(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              si_s,
  output logic [CMD_W-1:0]  cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              hdr_done,
  output logic              hdr_full,
  output logic              echo_vld,
  output logic              echo_bit
);

  localparam int HDR_W = CMD_W + ADDR_W;
  localparam int CNT_W = $clog2(HDR_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [HDR_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sr       <= '0;
      hdr_done <= 1'b0;
      echo_vld <= 1'b0;
      echo_bit <= 1'b0;
    end else if (!cs_act) begin
      cnt      <= '0;
      hdr_done <= 1'b0;
      echo_vld <= 1'b0;
    end else begin
      hdr_done <= 1'b0;
      if (sclk_rise && (cnt != CNT_W'(HDR_W))) begin
        sr       <= {sr[HDR_W-2:0], si_s};
        echo_bit <= si_s;
        echo_vld <= 1'b1;
        cnt      <= cnt + 1'b1;
        hdr_done <= (cnt == CNT_W'(HDR_W - 1));
      end else if (sclk_fall) begin
        echo_vld <= 1'b0;
      end
    end
  end

  assign cmd      = sr[HDR_W-1 -: CMD_W];
  assign addr     = sr[ADDR_W-1:0];
  assign hdr_full = (cnt == CNT_W'(HDR_W));

endmodule

// File: rtl/spi_rb_fetch.sv
module spi_rb_fetch
  import spi_rb_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_act,
  input  logic               hdr_done,
  input  logic [CMD_W-1:0]   cmd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               dsp_run,
  input  logic               next_word,
  output logic               mem_rd_en,
  output logic [SPACE_W-1:0] mem_space,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [DATA_W-1:0]  word_buf,
  output logic               acc_err
);

  space_e          sp;
  logic            cmd_ok;
  logic            blocked;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic            pend;
  fetch_mode_e     mode;

  assign sp         = space_e'(cmd[SPACE_W-1:0]);
  assign cmd_ok     = (cmd[CMD_W-1:SPACE_W] == '0) && (sp != SP_NONE);
  assign blocked    = cmd_ok && is_ram(sp) && dsp_run;
  assign start_addr = (sp == SP_PROG) ? '0 : addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_en <= 1'b0;
      mem_space <= '0;
      mem_addr  <= '0;
      nxt_addr  <= '0;
      pend      <= 1'b0;
      word_buf  <= '0;
      acc_err   <= 1'b0;
      mode      <= FM_IDLE;
    end else begin
      mem_rd_en <= 1'b0;
      pend      <= mem_rd_en;
      if (pend) begin
        word_buf <= mem_rdata;
      end
      if (!cs_act) begin
        mode <= FM_IDLE;
        pend <= 1'b0;
      end else if (hdr_done) begin
        if (cmd_ok && !blocked) begin
          mode      <= FM_READ;
          mem_rd_en <= 1'b1;
          mem_space <= sp;
          mem_addr  <= start_addr;
          nxt_addr  <= start_addr + 1'b1;
        end else begin
          mode     <= FM_ZERO;
          word_buf <= '0;
          if (blocked) begin
            acc_err <= 1'b1;
          end
        end
      end else if (next_word && (mode == FM_READ)) begin
        mem_rd_en <= 1'b1;
        mem_addr  <= nxt_addr;
        nxt_addr  <= nxt_addr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_fall,
  input  logic              echo_vld,
  input  logic              echo_bit,
  input  logic              hdr_full,
  input  logic [DATA_W-1:0] word_buf,
  output logic              so_q,
  output logic              oe_q,
  output logic              next_word
);

  localparam int BC_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sr;
  logic [BC_W-1:0]   bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_q      <= 1'b0;
      oe_q      <= 1'b0;
      next_word <= 1'b0;
      sr        <= '0;
      bitcnt    <= '0;
    end else begin
      next_word <= 1'b0;
      if (!cs_act) begin
        so_q   <= 1'b0;
        oe_q   <= 1'b0;
        bitcnt <= '0;
      end else if (sclk_fall) begin
        if (echo_vld) begin
          so_q <= echo_bit;
          oe_q <= 1'b1;
        end else if (hdr_full) begin
          oe_q <= 1'b1;
          if (bitcnt == '0) begin
            so_q      <= word_buf[DATA_W-1];
            sr        <= {word_buf[DATA_W-2:0], 1'b0};
            next_word <= 1'b1;
          end else begin
            so_q <= sr[DATA_W-1];
            sr   <= {sr[DATA_W-2:0], 1'b0};
          end
          bitcnt <= (bitcnt == BC_W'(DATA_W - 1)) ? '0 : bitcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_rb_slave.sv
module spi_rb_slave
  import spi_rb_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_csn,
  input  logic               spi_sclk,
  input  logic               spi_si,
  output logic               spi_so,
  output logic               spi_so_oe,
  input  logic               dsp_run,
  output logic               mem_rd_en,
  output logic [SPACE_W-1:0] mem_space,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               acc_err
);

  logic              sclk_rise, sclk_fall, cs_act, si_s;
  logic [CMD_W-1:0]  cmd;
  logic [ADDR_W-1:0] addr;
  logic              hdr_done, hdr_full, echo_vld, echo_bit;
  logic [DATA_W-1:0] word_buf;
  logic              next_word, so_q, oe_q;

  spi_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .csn_i(spi_csn), .si_i(spi_si),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .si_s(si_s)
  );

  spi_rb_hdr #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .si_s(si_s), .cmd(cmd), .addr(addr),
    .hdr_done(hdr_done), .hdr_full(hdr_full), .echo_vld(echo_vld), .echo_bit(echo_bit)
  );

  spi_rb_fetch #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .hdr_done(hdr_done), .cmd(cmd),
    .addr(addr), .dsp_run(dsp_run), .next_word(next_word), .mem_rd_en(mem_rd_en),
    .mem_space(mem_space), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .word_buf(word_buf), .acc_err(acc_err)
  );

  spi_rb_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .echo_vld(echo_vld), .echo_bit(echo_bit), .hdr_full(hdr_full),
    .word_buf(word_buf), .so_q(so_q), .oe_q(oe_q), .next_word(next_word)
  );

  // Raw chip select gates the enable so deselection releases the line at once
  assign spi_so_oe = oe_q & ~spi_csn;
  assign spi_so    = so_q & spi_so_oe;

endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_csn,
  input logic              spi_so_oe,
  input logic              mem_rd_en,
  input logic [2:0]        mem_space,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              acc_err
);

  a_r11_hiz_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_so_oe);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> acc_err);

  a_r2_no_null_space: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_space != 3'd0));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_en |=> $stable(mem_addr) || mem_rd_en);

endmodule

bind spi_rb_slave spi_rb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_so_oe(spi_so_oe),
  .mem_rd_en(mem_rd_en), .mem_space(mem_space), .mem_addr(mem_addr), .acc_err(acc_err)
);

// File: tb/sim_spi_rb_slave.sv
module sim_spi_rb_slave;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_csn = 1'b1, spi_sclk = 1'b0, spi_si = 1'b0;
  logic        spi_so, spi_so_oe;
  logic        dsp_run = 1'b0;
  logic        mem_rd_en;
  logic [2:0]  mem_space;
  logic [15:0] mem_addr;
  logic [23:0] mem_rdata;
  logic        acc_err;

  int checks = 0;
  int failures = 0;
  int rd_count = 0;
  logic cap [0:127];
  logic oe_first;

  always #10 clk = ~clk;

  spi_rb_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_si(spi_si),
    .spi_so(spi_so), .spi_so_oe(spi_so_oe), .dsp_run(dsp_run), .mem_rd_en(mem_rd_en),
    .mem_space(mem_space), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .acc_err(acc_err)
  );

  // memory model: one-cycle read latency, content derived from space and address
  always_ff @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= {mem_space, 5'b0, mem_addr};
      rd_count  <= rd_count + 1;
    end
  end

  function automatic logic [23:0] expv(input logic [2:0] sp, input logic [15:0] a);
    return {sp, 5'b0, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [15:0] addr,
                      input int nwords, input bit noise);
    logic [23:0] hdr;
    hdr = {cmd, addr};
    rd_count = 0;
    spi_csn = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 1; i <= 25 + 24 * nwords; i++) begin
      spi_si = (i <= 24) ? hdr[24 - i] : (noise ? (i[0] ^ i[2]) : 1'b0);
      repeat (H) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
      cap[i] = spi_so;
      if (i == 1) oe_first = spi_so_oe;
      spi_sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    spi_csn = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  function automatic logic [23:0] word(input int w);
    logic [23:0] v;
    for (int j = 0; j < 24; j++) v[23 - j] = cap[26 + 24 * w + j];
    return v;
  endfunction

  function automatic int echo_errs(input logic [23:0] hdr);
    int e = 0;
    for (int k = 0; k < 24; k++) if (cap[k + 2] !== hdr[23 - k]) e++;
    return e;
  endfunction

  task automatic t_reset;
    chk(spi_so_oe === 1'b0, "R1", "oe", {31'b0, spi_so_oe}, 0);
    chk(mem_rd_en === 1'b0, "R1", "rd_en", {31'b0, mem_rd_en}, 0);
    chk(acc_err === 1'b0, "R1", "err", {31'b0, acc_err}, 0);
  endtask

  task automatic t_echo_ctrl;
    dsp_run = 1'b1;
    xfer(8'h04, 16'hA5C3, 1, 1'b0);
    chk(oe_first === 1'b0, "R3", "oe before first fall", {31'b0, oe_first}, 0);
    chk(echo_errs(24'h04A5C3) == 0, "R3", "echo mismatches", echo_errs(24'h04A5C3), 0);
    chk(word(0) === expv(3'd4, 16'hA5C3), "R8", "ctrl word running", word(0), expv(3'd4, 16'hA5C3));
  endtask

  task automatic t_cram_burst;
    dsp_run = 1'b0;
    xfer(8'h02, 16'h0105, 3, 1'b0);
    for (int w = 0; w < 3; w++)
      chk(word(w) === expv(3'd2, 16'h0105 + 16'(w)), "R5", "cram burst word",
          word(w), expv(3'd2, 16'h0105 + 16'(w)));
    chk(word(0) === expv(3'd2, 16'h0105), "R4", "first data word", word(0), expv(3'd2, 16'h0105));
  endtask

  task automatic t_pram_zero;
    dsp_run = 1'b0;
    xfer(8'h01, 16'h1234, 2, 1'b0);
    chk(word(0) === expv(3'd1, 16'h0000), "R6", "pram word0", word(0), expv(3'd1, 16'h0000));
    chk(word(1) === expv(3'd1, 16'h0001), "R6", "pram word1", word(1), expv(3'd1, 16'h0001));
  endtask

  task automatic t_blocked;
    dsp_run = 1'b1;
    xfer(8'h03, 16'h0040, 2, 1'b0);
    chk(word(0) === 24'h0 && word(1) === 24'h0, "R7", "blocked data", word(0) | word(1), 0);
    chk(rd_count == 0, "R7", "blocked reads", rd_count, 0);
    chk(acc_err === 1'b1, "R7", "err set", {31'b0, acc_err}, 1);
    xfer(8'h07, 16'h0002, 1, 1'b0);
    chk(word(0) === expv(3'd7, 16'h0002), "R8", "errstat word", word(0), expv(3'd7, 16'h0002));
    chk(acc_err === 1'b1, "R7", "err sticky", {31'b0, acc_err}, 1);
  endtask

  task automatic t_si_ignored;
    dsp_run = 1'b0;
    xfer(8'h05, 16'h0010, 2, 1'b1);
    chk(echo_errs(24'h050010) == 0, "R2", "header with noise", echo_errs(24'h050010), 0);
    chk(word(0) === expv(3'd5, 16'h0010), "R10", "id word0", word(0), expv(3'd5, 16'h0010));
    chk(word(1) === expv(3'd5, 16'h0011), "R10", "id word1", word(1), expv(3'd5, 16'h0011));
  endtask

  task automatic t_wrap;
    dsp_run = 1'b1;
    xfer(8'h06, 16'hFFFF, 2, 1'b0);
    chk(word(0) === expv(3'd6, 16'hFFFF), "R5", "wrap word0", word(0), expv(3'd6, 16'hFFFF));
    chk(word(1) === expv(3'd6, 16'h0000), "R5", "wrap word1", word(1), expv(3'd6, 16'h0000));
  endtask

  task automatic t_invalid;
    logic e0;
    e0 = acc_err;
    xfer(8'h80, 16'h0001, 1, 1'b0);
    chk(word(0) === 24'h0, "R9", "invalid data", word(0), 0);
    chk(rd_count == 0, "R9", "invalid reads", rd_count, 0);
    chk(acc_err === e0, "R9", "err unchanged", {31'b0, acc_err}, {31'b0, e0});
    xfer(8'h00, 16'h0001, 1, 1'b0);
    chk(word(0) === 24'h0 && rd_count == 0, "R9", "null command", word(0), 0);
  endtask

  task automatic t_abort;
    dsp_run = 1'b1;
    spi_csn = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      spi_si = i[0];
      repeat (H) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    chk(spi_so_oe === 1'b1, "R11", "oe during header", {31'b0, spi_so_oe}, 1);
    spi_csn = 1'b1;
    #1;
    chk(spi_so_oe === 1'b0, "R11", "oe on deselect", {31'b0, spi_so_oe}, 0);
    repeat (H) @(negedge clk);
    xfer(8'h04, 16'h0077, 1, 1'b0);
    chk(echo_errs(24'h040077) == 0, "R11", "fresh header echo", echo_errs(24'h040077), 0);
    chk(word(0) === expv(3'd4, 16'h0077), "R11", "fresh header data", word(0), expv(3'd4, 16'h0077));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_echo_ctrl;
    t_cram_burst;
    t_pram_zero;
    t_blocked;
    t_si_ignored;
    t_wrap;
    t_invalid;
    t_abort;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule